// File: doc/BRIEF.md
# I2C Slave Receive Engine with Clock Stretching

This block is the receive side of an I2C target. It watches the SCL and SDA lines through a synchronizer on the system clock and finds Start and Stop conditions. It matches a 7-bit address, or a 10-bit address sent as a header byte followed by a low byte. It acknowledges the address and every data byte that follows, capturing each data byte MSB first.

Software sees three event flags in a status register: address matched, receive data ready and stop seen. When the event interrupt is enabled, `irq_o` is high while any of these flags is set. The flags are cleared only by fixed, ordered register accesses. The block pulls SCL low while an event that needs service is still pending, so the master waits for software instead of losing data. Both bus lines are open drain: an output of 1 pulls the line low, and an output of 0 releases it.

The controller has these states:
- `ST_IDLE`: no transfer.
- `ST_HDR`: receiving the first address byte.
- `ST_HDR_ACK`: acknowledging a matching 10-bit header.
- `ST_LOW_ADDR`: receiving the second byte of a 10-bit address.
- `ST_ADDR_ACK`: acknowledging the final address byte.
- `ST_ADDR_HOLD`: stretching SCL while the address flag is pending.
- `ST_DATA`: receiving a data byte.
- `ST_DATA_HOLD`: stretching SCL while an earlier byte is still unread.
- `ST_DATA_ACK`: acknowledging a data byte.

The transitions are as follows:
- A Start moves any state to `ST_HDR`. A Stop, or clearing the enable bit, moves any state to `ST_IDLE`.
- `ST_HDR` goes to `ST_ADDR_ACK` on a 7-bit match or to `ST_HDR_ACK` on a 10-bit header match. Otherwise it returns to `ST_IDLE`.
- `ST_HDR_ACK` goes to `ST_LOW_ADDR`.
- `ST_LOW_ADDR` goes to `ST_ADDR_ACK` on a match, otherwise to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_ADDR_HOLD` if the flag is still set, otherwise to `ST_DATA`. `ST_ADDR_HOLD` goes to `ST_DATA` once the flag clears.
- `ST_DATA` goes to `ST_DATA_ACK`, or to `ST_DATA_HOLD` when the earlier byte is unread. `ST_DATA_HOLD` goes to `ST_DATA_ACK` once the data is read.
- `ST_DATA_ACK` goes to `ST_DATA`.

Top module: `i2c_slave_rx`

## Requirements
- R1: A 7-bit address byte equal to {OWN_ADDR[6:0], 0} is acknowledged, with SDA low during the ninth clock. It sets the address flag (status-1 register at select 1, bit 0). After that ninth clock, SCL is held low while the flag stays set.
- R2: The address flag clears only when a status-1 read is followed by a status-2 read (select 2). A status-2 read with no earlier status-1 read taken while the flag was set leaves the flag set and SCL held.
- R3: Each data byte is captured MSB first and acknowledged. Its arrival sets the receive-ready flag (status-1 bit 1). Reading the data register (select 3) returns the byte and clears the flag.
- R4: If the receive-ready flag is still set when the eighth bit of the next byte has been clocked, SCL is held low and the new byte is kept aside. After the data register is read, the new byte is loaded, the flag is set again and the byte is acknowledged.
- R5: A Stop seen while addressed sets the stop flag (status-1 bit 2). `irq_o` is high while control bit 1 (event interrupt enable) is set and any flag is set.
- R6: The stop flag clears only when a status-1 read is followed by a write to the control register (select 0). A control write alone leaves it set.
- R7: When both the address and stop flags are set, one status-1 read, then a status-2 read, then a control write, clears both.
- R8: With control bit 2 set (10-bit mode), the header byte {11110, OWN_ADDR[9:8], 0} is acknowledged without setting a flag. The next byte, if equal to OWN_ADDR[7:0], is acknowledged and sets the address flag. A header with other upper bits is not acknowledged.
- R9: A non-matching address is not acknowledged. The rest of that transfer, including its Stop, leaves every flag clear and SCL free.
- R10: After reset, both line pulls are released, the control register reads 0 and no flag is set. Control bit 0 enables the engine, and a Stop always returns it to idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| reg_sel | input | 2 | Register select: 0 control, 1 status-1, 2 status-2, 3 data |
| reg_rd | input | 1 | Read strobe, side effects on the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Event interrupt |

## Verification
The bench builds the block with OWN_ADDR = 10'h2D6 and two synchronizer stages. The 7-bit address is then 0x56 and the 10-bit header carries non-zero upper bits (10). This brings both address paths and a header mismatch on the upper bits within reach. A slow bus model with a 25-cycle quarter period gives time to hold the master in both stretch states and to run out-of-order clearing accesses while SCL is held. Randomly chosen addresses, some matching and some not, and random payloads exercise acknowledge and capture.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_ACK,
        ST_LOW_ADDR,
        ST_ADDR_ACK,
        ST_ADDR_HOLD,
        ST_DATA,
        ST_DATA_HOLD,
        ST_DATA_ACK
    } srx_state_e;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_STAT1 = 2'd1;
    localparam logic [1:0] SEL_STAT2 = 2'd2;
    localparam logic [1:0] SEL_DATA  = 2'd3;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_IE  = 1;
    localparam int CTRL_TEN = 2;

    localparam logic [4:0] TEN_MARK = 5'b11110;

endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_srx_fsm.sv
module i2c_srx_fsm
    import i2c_srx_pkg::*;
#(
    parameter logic [9:0] OWN_ADDR = 10'h05A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ten,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       addr_pend,
    input  logic       rxne_pend,
    output logic       ev_addr,
    output logic       ev_byte,
    output logic       ev_stop,
    output logic [7:0] rx_byte,
    output logic       active,
    output logic       scl_low,
    output logic       sda_low
);
    localparam logic [7:0] HDR_MATCH  = {TEN_MARK, OWN_ADDR[9:8], 1'b0};
    localparam logic [7:0] ADDR7_MATCH = {OWN_ADDR[6:0], 1'b0};

    srx_state_e state, state_n;
    logic [3:0] cnt, cnt_n;
    logic [7:0] shreg, sh_n;
    logic       act_n;
    logic       byte_done;

    assign byte_done = scl_fall && (cnt == 4'd8);
    assign rx_byte   = shreg;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sh_n    = shreg;
        act_n   = active;
        ev_addr = 1'b0;
        ev_byte = 1'b0;
        ev_stop = 1'b0;
        if (!en) begin
            state_n = ST_IDLE;
            act_n   = 1'b0;
        end else if (stop_det) begin
            ev_stop = active;
            state_n = ST_IDLE;
            act_n   = 1'b0;
        end else if (start_det) begin
            state_n = ST_HDR;
            cnt_n   = 4'd0;
            act_n   = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_HDR, ST_LOW_ADDR, ST_DATA: begin
                    if (scl_rise && cnt != 4'd8) begin
                        sh_n  = {shreg[6:0], sda_s};
                        cnt_n = cnt + 4'd1;
                    end else if (byte_done) begin
                        if (state == ST_HDR && ten) begin
                            state_n = (shreg == HDR_MATCH) ? ST_HDR_ACK : ST_IDLE;
                        end else if ((state == ST_HDR && shreg == ADDR7_MATCH) ||
                                     (state == ST_LOW_ADDR && shreg == OWN_ADDR[7:0])) begin
                            state_n = ST_ADDR_ACK;
                            ev_addr = 1'b1;
                            act_n   = 1'b1;
                        end else if (state == ST_DATA) begin
                            if (rxne_pend) begin
                                state_n = ST_DATA_HOLD;
                            end else begin
                                ev_byte = 1'b1;
                                state_n = ST_DATA_ACK;
                            end
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_HDR_ACK: if (scl_fall) begin
                    state_n = ST_LOW_ADDR;
                    cnt_n   = 4'd0;
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    state_n = addr_pend ? ST_ADDR_HOLD : ST_DATA;
                    cnt_n   = 4'd0;
                end
                ST_ADDR_HOLD: if (!addr_pend) state_n = ST_DATA;
                ST_DATA_HOLD: if (!rxne_pend) begin
                    ev_byte = 1'b1;
                    state_n = ST_DATA_ACK;
                end
                ST_DATA_ACK: if (scl_fall) begin
                    state_n = ST_DATA;
                    cnt_n   = 4'd0;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= 4'd0;
            shreg  <= 8'd0;
            active <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            shreg  <= sh_n;
            active <= act_n;
        end
    end

    always_comb begin
        scl_low = (state == ST_ADDR_HOLD) || (state == ST_DATA_HOLD);
        sda_low = (state == ST_HDR_ACK) || (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
    end

    // R10: a Stop always leaves the engine idle with both lines free
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !scl_low && !sda_low));

    // R10: the engine never pulls both lines at once
    p_pull_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_low && sda_low));

    // R1: leaving the address hold only once the flag is gone
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_HOLD && addr_pend && en && !stop_det && !start_det)
            |=> state == ST_ADDR_HOLD);

endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
    import i2c_srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_addr,
    input  logic       ev_byte,
    input  logic       ev_stop,
    input  logic [7:0] rx_byte,
    input  logic       active,
    output logic       en,
    output logic       ten,
    output logic       addr_flag,
    output logic       rxne_flag,
    output logic       irq
);
    logic [7:0] ctrl_q;
    logic [7:0] data_q;
    logic       stop_flag;
    logic       arm_addr, arm_stop;
    logic       rd_stat1, rd_stat2, rd_data, wr_ctrl;

    assign rd_stat1 = reg_rd && reg_sel == SEL_STAT1;
    assign rd_stat2 = reg_rd && reg_sel == SEL_STAT2;
    assign rd_data  = reg_rd && reg_sel == SEL_DATA;
    assign wr_ctrl  = reg_wr && reg_sel == SEL_CTRL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= 8'd0;
            data_q    <= 8'd0;
            addr_flag <= 1'b0;
            rxne_flag <= 1'b0;
            stop_flag <= 1'b0;
            arm_addr  <= 1'b0;
            arm_stop  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata;
            if (rd_stat1) begin
                arm_addr <= addr_flag;
                arm_stop <= stop_flag;
            end else begin
                if (rd_stat2) arm_addr <= 1'b0;
                if (wr_ctrl)  arm_stop <= 1'b0;
            end
            if (ev_addr)                   addr_flag <= 1'b1;
            else if (rd_stat2 && arm_addr) addr_flag <= 1'b0;
            if (ev_stop)                   stop_flag <= 1'b1;
            else if (wr_ctrl && arm_stop)  stop_flag <= 1'b0;
            if (ev_byte) begin
                data_q    <= rx_byte;
                rxne_flag <= 1'b1;
            end else if (rd_data) begin
                rxne_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL:  reg_rdata = ctrl_q;
            SEL_STAT1: reg_rdata = {5'd0, stop_flag, rxne_flag, addr_flag};
            SEL_STAT2: reg_rdata = {7'd0, active};
            default:   reg_rdata = data_q;
        endcase
    end

    assign en  = ctrl_q[CTRL_EN];
    assign ten = ctrl_q[CTRL_TEN];
    assign irq = ctrl_q[CTRL_IE] && (addr_flag || rxne_flag || stop_flag);

    // R2: the address flag only falls after a status-2 read
    p_addr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_flag) |-> $past(reg_rd && reg_sel == SEL_STAT2));

    // R6: the stop flag only falls after a control write
    p_stop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_flag) |-> $past(reg_wr && reg_sel == SEL_CTRL));

    // R3: the receive flag only falls after a data read
    p_rxne_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxne_flag) |-> $past(reg_rd && reg_sel == SEL_DATA));

    // R4: a new byte is never delivered over an unread one
    p_no_overwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_byte |-> !rxne_flag);

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
    parameter logic [9:0] OWN_ADDR    = 10'h05A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_low_o,
    output logic       sda_low_o,
    input  logic [1:0] reg_sel,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       en, ten, addr_flag, rxne_flag, active;
    logic       ev_addr, ev_byte, ev_stop;
    logic [7:0] rx_byte;

    i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_srx_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .ten(ten), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .addr_pend(addr_flag), .rxne_pend(rxne_flag),
        .ev_addr(ev_addr), .ev_byte(ev_byte), .ev_stop(ev_stop),
        .rx_byte(rx_byte), .active(active),
        .scl_low(scl_low_o), .sda_low(sda_low_o)
    );

    i2c_srx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_addr(ev_addr), .ev_byte(ev_byte), .ev_stop(ev_stop),
        .rx_byte(rx_byte), .active(active), .en(en), .ten(ten),
        .addr_flag(addr_flag), .rxne_flag(rxne_flag), .irq(irq_o)
    );

endmodule

// File: tb/sim_i2c_slave_rx.sv
`timescale 1ns/1ps
module sim_i2c_slave_rx;
    localparam logic [9:0] OWN = 10'h2D6;
    localparam int Q = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line, scl_low_o, sda_low_o, irq_o;
    logic [1:0] reg_sel = 2'd0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;
    int total = 0, fails = 0;
    logic m_busy = 1'b0, bg_ack;
    logic [7:0] bg_data;

    always #5 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_low_o);
    assign sda_line = !(m_sda_low || sda_low_o);

    i2c_slave_rx #(.OWN_ADDR(OWN), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .reg_sel(reg_sel),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [7:0] addr7(input logic [6:0] a);
        return {a, 1'b0};
    endfunction
    function automatic logic [7:0] hdr10(input logic [9:0] a);
        return {5'b11110, a[9:8], 1'b0};
    endfunction
    function automatic logic [7:0] stat1(input logic a, input logic r, input logic s);
        return {5'd0, s, r, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; wait_high(); tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; tick(Q);
        m_scl_low = 1'b0; wait_high(); tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    task automatic m_bit(input logic b, output logic rb);
        m_sda_low = !b; tick(Q);
        m_scl_low = 1'b0; wait_high(); tick(Q);
        rb = sda_line;
        m_scl_low = 1'b1; tick(Q);
    endtask

    task automatic m_byte(input logic [7:0] d, output logic ack_low);
        logic rb;
        for (int i = 7; i >= 0; i--) m_bit(d[i], rb);
        m_bit(1'b1, rb);
        ack_low = !rb;
        m_busy = 1'b0;
    endtask

    task automatic bg_byte(input logic [7:0] d);
        bg_data = d;
        m_busy = 1'b1;
        fork
            m_byte(bg_data, bg_ack);
        join_none
    endtask

    task automatic wait_master();
        while (m_busy) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic ack;
        int unsigned seed;
        seed = $urandom(32'd4242);
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R10: reset state
        chk("R10 scl pull", scl_low_o, 0);
        chk("R10 sda pull", sda_low_o, 0);
        chk("R10 irq", irq_o, 0);
        rd(2'd0, v); chk("R10 ctrl", v, 0);
        rd(2'd1, v); chk("R10 stat1", v, 0);
        wr(2'd0, 8'h03);

        // R1/R2/R3: 7-bit address, stretch, ordered clear
        m_start();
        m_byte(addr7(OWN[6:0]), ack); chk("R1 addr ack", ack, 1);
        bg_byte(8'hA5);
        tick(200); chk("R1 scl held", scl_line, 0);
        rd(2'd2, v); tick(100);
        chk("R2 lone stat2 keeps hold", scl_line, 0);
        chk("R2 master stalled", m_busy, 1);
        rd(2'd1, v); chk("R1 addr flag", v, stat1(1, 0, 0));
        rd(2'd2, v);
        wait_master(); chk("R3 data ack", bg_ack, 1);
        rd(2'd1, v); chk("R3 rxne", v, stat1(0, 1, 0));
        chk("R5 irq on rxne", irq_o, 1);
        rd(2'd3, v); chk("R3 data", v, 8'hA5);
        rd(2'd1, v); chk("R3 rxne clear", v, 0);

        // R3: random payload
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            m_byte(d, ack); chk("R3 rand ack", ack, 1);
            rd(2'd3, v); chk("R3 rand data", v, d);
        end

        // R4: overrun stretch
        m_byte(8'h3C, ack);
        bg_byte(8'hC3);
        tick(1500);
        chk("R4 scl held", scl_line, 0);
        chk("R4 master stalled", m_busy, 1);
        rd(2'd3, v); chk("R4 first byte", v, 8'h3C);
        wait_master(); chk("R4 late ack", bg_ack, 1);
        rd(2'd3, v); chk("R4 second byte", v, 8'hC3);

        // R5/R6: stop flag
        m_stop(); tick(10);
        chk("R5 irq on stop", irq_o, 1);
        wr(2'd0, 8'h03); tick(2);
        chk("R6 lone ctrl write keeps stop", irq_o, 1);
        rd(2'd1, v); chk("R5 stop flag", v, stat1(0, 0, 1));
        wr(2'd0, 8'h03);
        rd(2'd1, v); chk("R6 stop cleared", v, 0);
        chk("R6 irq low", irq_o, 0);

        // R7: stop flag left pending, then a new address match
        m_start(); m_byte(addr7(OWN[6:0]), ack);
        tick(100); rd(2'd1, v); rd(2'd2, v);
        m_byte(8'h77, ack); rd(2'd3, v);
        m_stop(); tick(10);
        m_start(); m_byte(addr7(OWN[6:0]), ack); chk("R7 ack", ack, 1);
        tick(100);
        rd(2'd1, v); chk("R7 both flags", v, stat1(1, 0, 1));
        rd(2'd2, v);
        wr(2'd0, 8'h03);
        rd(2'd1, v); chk("R7 both cleared", v, 0);
        m_byte(8'h12, ack); rd(2'd3, v); chk("R7 data", v, 8'h12);
        m_stop(); tick(10);
        rd(2'd1, v); wr(2'd0, 8'h03);

        // R9: mismatch is ignored
        m_start();
        m_byte(addr7(7'h2B), ack); chk("R9 nack addr", ack, 0);
        m_byte(8'h99, ack); chk("R9 nack data", ack, 0);
        m_stop(); tick(10);
        rd(2'd1, v); chk("R9 no flags", v, 0);

        // R1/R9: random addresses in 7-bit mode
        for (int t = 0; t < 6; t++) begin
            logic [6:0] a;
            logic hit;
            int nb;
            a = ($urandom % 2) ? OWN[6:0] : 7'($urandom);
            hit = (a == OWN[6:0]);
            m_start();
            m_byte(addr7(a), ack); chk("R1 rand addr ack", ack, hit);
            if (hit) begin
                tick(100); chk("R1 rand hold", scl_line, 0);
                rd(2'd1, v); chk("R1 rand flag", v, stat1(1, 0, 0));
                rd(2'd2, v);
            end
            nb = 1 + int'($urandom % 3);
            for (int k = 0; k < nb; k++) begin
                logic [7:0] d;
                d = 8'($urandom);
                m_byte(d, ack); chk("R3 rand xfer ack", ack, hit);
                if (hit) begin
                    rd(2'd3, v); chk("R3 rand xfer data", v, d);
                end
            end
            m_stop(); tick(10);
            rd(2'd1, v); chk("R5 rand stop", v, stat1(0, 0, hit));
            if (hit) wr(2'd0, 8'h03);
        end

        // R8: 10-bit mode
        wr(2'd0, 8'h07);
        m_start();
        m_byte(hdr10(OWN), ack); chk("R8 header ack", ack, 1);
        rd(2'd1, v); chk("R8 no flag after header", v, 0);
        m_byte(OWN[7:0], ack); chk("R8 low byte ack", ack, 1);
        tick(100); chk("R8 hold", scl_line, 0);
        rd(2'd1, v); chk("R8 addr flag", v, stat1(1, 0, 0));
        rd(2'd2, v);
        m_byte(8'h5E, ack); chk("R8 data ack", ack, 1);
        rd(2'd3, v); chk("R8 data", v, 8'h5E);
        m_stop(); tick(10);
        rd(2'd1, v); chk("R8 stop", v, stat1(0, 0, 1));
        wr(2'd0, 8'h07);
        m_start();
        m_byte(hdr10(OWN ^ 10'h100), ack); chk("R8 wrong header nack", ack, 0);
        m_stop(); tick(10);
        rd(2'd1, v); chk("R8 wrong header no flags", v, 0);
        chk("R10 idle lines", {scl_low_o, sda_low_o}, 0);

        summary();
        $finish;
    end
endmodule